// File: doc/BRIEF.md
# Sticky Error Code Collector

This block gathers single-cycle error pulses from a group of FIFOs and from two control state machines into one 32-bit sticky error code. A FIFO error marks two things at once: which FIFO reported it (a source bit) and what kind of fault it was (a type bit). A state-machine error marks its own bit, raises a one-cycle fatal alert and, when enabled, holds an interrupt. Bits stay set until software clears them by writing ones.

A test port lets software inject an error on purpose. Writing a bit number into it produces one pulse on that bit, exactly as if the real source had fired. This exercises the whole path to the register, the alert and the interrupt. Injection is refused while the global register write enable is low.

Top module: `errcode_top`

## Requirements
- R1: After reset `err_code_o` is 0 and `fatal_alert_o` and `irq_o` are 0.
- R2: An error pulse of any kind from FIFO i sets source bit i of `err_code_o` after the next rising edge. FIFO 0 is the raw sample FIFO, FIFO 1 is the observe FIFO and FIFO 2 is the final FIFO.
- R3: At the same edge as the source bit, a write-while-full pulse sets bit 28, a read-while-empty pulse sets bit 29, and a full-and-empty state pulse sets bit 30.
- R4: An illegal-state pulse from the acknowledge-stage machine sets bit 20. An illegal-state pulse from the main-stage machine sets bit 21.
- R5: `fatal_alert_o` is high for exactly the one cycle after each edge that captures a state-machine error, and low otherwise.
- R6: `irq_o` is high exactly when `irq_en_i` is 1 and bit 20 or bit 21 is set.
- R7: A set bit stays set until a clear write (`clr_we_i`) has a 1 at that position of `clr_mask_i`. Clearing one bit leaves the other bits unchanged.
- R8: When a clear and a new error for the same bit arrive in the same cycle, the bit stays set.
- R9: A test write (`test_we_i`) with index k pulses bit k once, with the same timing and the same side effects as a real error. Index 20 or 21 also raises the alert and the interrupt. Index 28 sets only bit 28.
- R10: A test write is ignored while `regs_wen_i` is 0.
- R11: Bits other than 0 to 2, 20, 21 and 28 to 30 always read 0, including after a test write that selects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_wr_err_i | input | 3 | Per-FIFO write-while-full pulse |
| fifo_rd_err_i | input | 3 | Per-FIFO read-while-empty pulse |
| fifo_st_err_i | input | 3 | Per-FIFO full-and-empty state pulse |
| ack_fsm_err_i | input | 1 | Acknowledge-stage machine illegal-state pulse |
| main_fsm_err_i | input | 1 | Main-stage machine illegal-state pulse |
| regs_wen_i | input | 1 | Global register write enable; gates test writes |
| irq_en_i | input | 1 | Interrupt enable |
| clr_we_i | input | 1 | Clear strobe |
| clr_mask_i | input | 32 | Write-one-to-clear mask |
| test_we_i | input | 1 | Test injection strobe |
| test_idx_i | input | 5 | Bit number to inject |
| err_code_o | output | 32 | Sticky error code |
| fatal_alert_o | output | 1 | One-cycle fatal alert pulse |
| irq_o | output | 1 | State-machine error interrupt |

## Verification
Each FIFO is driven with each of the three error kinds. This shows that the source bit follows the FIFO index and the type bit follows the kind, independently of each other. The two state machines are pulsed separately, with the interrupt enable on and off, to separate the alert pulse from the level interrupt. Injections at a source index, a type index, a state-machine index and an unused index, with the write enable open and closed, show that injection matches the real path and is gated. A clear that coincides with a fresh error shows that the set wins.

// File: rtl/errcode_pkg.sv
package errcode_pkg;
  localparam int ERR_W  = 32;
  localparam int IDX_W  = $clog2(ERR_W);
  localparam int N_FIFO = 3;

  // Bit positions decoded by software
  localparam int BIT_ACK_FSM    = 20;
  localparam int BIT_MAIN_FSM   = 21;
  localparam int BIT_WR_FULL    = 28;
  localparam int BIT_RD_EMPTY   = 29;
  localparam int BIT_FIFO_STATE = 30;

  localparam logic [ERR_W-1:0] IMPL_MASK =
      ERR_W'((64'd1 << N_FIFO) - 64'd1)
    | (ERR_W'(1) << BIT_ACK_FSM)  | (ERR_W'(1) << BIT_MAIN_FSM)
    | (ERR_W'(1) << BIT_WR_FULL)  | (ERR_W'(1) << BIT_RD_EMPTY)
    | (ERR_W'(1) << BIT_FIFO_STATE);
endpackage

// File: rtl/errcode_event_map.sv
module errcode_event_map
  import errcode_pkg::*;
#(
  parameter int NFIFO = N_FIFO
) (
  input  logic [NFIFO-1:0] wr_err_i,
  input  logic [NFIFO-1:0] rd_err_i,
  input  logic [NFIFO-1:0] st_err_i,
  input  logic             ack_err_i,
  input  logic             main_err_i,
  input  logic             inject_i,
  input  logic [IDX_W-1:0] inject_idx_i,
  output logic [ERR_W-1:0] event_o
);
  logic [NFIFO-1:0] src_hit;
  logic [ERR_W-1:0] real_ev;
  logic [ERR_W-1:0] forced_ev;

  // One source bit per FIFO, any error kind
  for (genvar g = 0; g < NFIFO; g++) begin : g_src
    assign src_hit[g] = wr_err_i[g] | rd_err_i[g] | st_err_i[g];
  end

  always_comb begin
    real_ev                 = '0;
    real_ev[NFIFO-1:0]      = src_hit;
    real_ev[BIT_WR_FULL]    = |wr_err_i;
    real_ev[BIT_RD_EMPTY]   = |rd_err_i;
    real_ev[BIT_FIFO_STATE] = |st_err_i;
    real_ev[BIT_ACK_FSM]    = ack_err_i;
    real_ev[BIT_MAIN_FSM]   = main_err_i;
  end

  assign forced_ev = inject_i ? (ERR_W'(1) << inject_idx_i) : '0;
  assign event_o   = (real_ev | forced_ev) & IMPL_MASK;
endmodule

// File: rtl/errcode_sticky.sv
module errcode_sticky
  import errcode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] event_i,
  input  logic             clr_we_i,
  input  logic [ERR_W-1:0] clr_mask_i,
  output logic [ERR_W-1:0] code_o
);
  logic [ERR_W-1:0] code_q, code_d;
  logic             code_en;

  // Set has priority over clear
  always_comb begin
    code_en = clr_we_i | (|event_i);
    code_d  = (code_q & ~(clr_we_i ? clr_mask_i : '0)) | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/errcode_alert.sv
module errcode_alert
  import errcode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] event_i,
  input  logic [ERR_W-1:0] code_i,
  input  logic             irq_en_i,
  output logic             alert_o,
  output logic             irq_o
);
  logic alert_q, alert_d;

  always_comb alert_d = event_i[BIT_ACK_FSM] | event_i[BIT_MAIN_FSM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= alert_d;
  end

  assign alert_o = alert_q;
  assign irq_o   = irq_en_i & (code_i[BIT_ACK_FSM] | code_i[BIT_MAIN_FSM]);
endmodule

// File: rtl/errcode_top.sv
module errcode_top
  import errcode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FIFO-1:0] fifo_wr_err_i,
  input  logic [N_FIFO-1:0] fifo_rd_err_i,
  input  logic [N_FIFO-1:0] fifo_st_err_i,
  input  logic              ack_fsm_err_i,
  input  logic              main_fsm_err_i,
  input  logic              regs_wen_i,
  input  logic              irq_en_i,
  input  logic              clr_we_i,
  input  logic [ERR_W-1:0]  clr_mask_i,
  input  logic              test_we_i,
  input  logic [IDX_W-1:0]  test_idx_i,
  output logic [ERR_W-1:0]  err_code_o,
  output logic              fatal_alert_o,
  output logic              irq_o
);
  logic [ERR_W-1:0] ev;
  logic             inject;

  assign inject = test_we_i & regs_wen_i;

  errcode_event_map #(.NFIFO(N_FIFO)) i_map (
    .wr_err_i     (fifo_wr_err_i),
    .rd_err_i     (fifo_rd_err_i),
    .st_err_i     (fifo_st_err_i),
    .ack_err_i    (ack_fsm_err_i),
    .main_err_i   (main_fsm_err_i),
    .inject_i     (inject),
    .inject_idx_i (test_idx_i),
    .event_o      (ev)
  );

  errcode_sticky i_sticky (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (ev),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .code_o     (err_code_o)
  );

  errcode_alert i_alert (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (ev),
    .code_i   (err_code_o),
    .irq_en_i (irq_en_i),
    .alert_o  (fatal_alert_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/errcode_chk.sv
module errcode_chk
  import errcode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_FIFO-1:0] fifo_wr_err_i,
  input logic              ack_fsm_err_i,
  input logic              main_fsm_err_i,
  input logic              irq_en_i,
  input logic              clr_we_i,
  input logic [ERR_W-1:0]  clr_mask_i,
  input logic [ERR_W-1:0]  err_code_o,
  input logic              fatal_alert_o,
  input logic              irq_o
);
  logic [ERR_W-1:0] kept;
  assign kept = err_code_o & ~(clr_we_i ? clr_mask_i : '0);

  // R7: bits not cleared stay set
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_code_o & $past(kept)) == $past(kept)));

  // R3: write-while-full sets its type bit
  assert_wr_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fifo_wr_err_i) |=> err_code_o[BIT_WR_FULL]);

  // R5: state-machine error gives alert next cycle
  assert_alert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fsm_err_i | main_fsm_err_i) |=> fatal_alert_o);

  // R5: alert only with a recorded state-machine bit
  assert_alert_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_alert_o |-> (err_code_o[BIT_ACK_FSM] | err_code_o[BIT_MAIN_FSM]));

  // R6: interrupt requires enable
  assert_irq_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);

  // R11: unused bits stay zero
  assert_unused_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o & ~IMPL_MASK) == '0);
endmodule

bind errcode_top errcode_chk i_errcode_chk (.*);

// File: tb/test_errcode_top.sv
`timescale 1ns/1ps
module test_errcode_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  fifo_wr_err_i, fifo_rd_err_i, fifo_st_err_i;
  logic        ack_fsm_err_i, main_fsm_err_i, regs_wen_i, irq_en_i;
  logic        clr_we_i, test_we_i;
  logic [31:0] clr_mask_i;
  logic [4:0]  test_idx_i;
  logic [31:0] err_code_o;
  logic        fatal_alert_o, irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  errcode_top i_errcode_top (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fifo_wr_err_i = '0; fifo_rd_err_i = '0; fifo_st_err_i = '0;
    ack_fsm_err_i = 0; main_fsm_err_i = 0;
    clr_we_i = 0; clr_mask_i = '0; test_we_i = 0; test_idx_i = '0;
  endtask

  // inputs set at negedge; capture at posedge; sample at next negedge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic clear_all();
    clr_we_i = 1; clr_mask_i = '1;
    step();
  endtask

  task automatic t_reset();
    chk("R1 code", err_code_o, 32'h0);
    chk("R1 alert", {31'b0, fatal_alert_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_fifo();
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 3; k++) begin
        clear_all();
        case (k)
          0: fifo_wr_err_i[f] = 1'b1;
          1: fifo_rd_err_i[f] = 1'b1;
          default: fifo_st_err_i[f] = 1'b1;
        endcase
        step();
        chk("R2/R3 fifo source+type", err_code_o,
            (32'd1 << f) | (32'd1 << (28 + k)));
        chk("R5 no alert for fifo", {31'b0, fatal_alert_o}, 32'h0);
      end
    end
  endtask

  task automatic t_fsm();
    clear_all();
    irq_en_i = 0;
    ack_fsm_err_i = 1;
    step();
    chk("R4 ack bit", err_code_o, 32'h0010_0000);
    chk("R5 alert pulse", {31'b0, fatal_alert_o}, 32'h1);
    chk("R6 irq masked", {31'b0, irq_o}, 32'h0);
    step();
    chk("R5 alert ends", {31'b0, fatal_alert_o}, 32'h0);
    irq_en_i = 1;
    #1;
    chk("R6 irq enabled", {31'b0, irq_o}, 32'h1);
    main_fsm_err_i = 1;
    step();
    chk("R4 main bit", err_code_o, 32'h0030_0000);
    chk("R5 alert main", {31'b0, fatal_alert_o}, 32'h1);
    clear_all();
    chk("R6 irq after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_sticky();
    clear_all();
    fifo_rd_err_i = 3'b010;
    ack_fsm_err_i = 1;
    step();
    step(); step();
    chk("R7 holds", err_code_o, 32'h2010_0002);
    clr_we_i = 1; clr_mask_i = 32'h2000_0000;
    step();
    chk("R7 partial clear", err_code_o, 32'h0010_0002);
  endtask

  task automatic t_collide();
    clear_all();
    fifo_wr_err_i = 3'b001;
    step();
    clr_we_i = 1; clr_mask_i = 32'h1000_0001;
    fifo_wr_err_i = 3'b001;
    step();
    chk("R8 set wins", err_code_o, 32'h1000_0001);
  endtask

  task automatic t_force();
    clear_all();
    irq_en_i = 1; regs_wen_i = 1;
    test_we_i = 1; test_idx_i = 5'd21;
    step();
    chk("R9 force fsm bit", err_code_o, 32'h0020_0000);
    chk("R9 force alert", {31'b0, fatal_alert_o}, 32'h1);
    chk("R9 force irq", {31'b0, irq_o}, 32'h1);
    step();
    chk("R9 single pulse", {31'b0, fatal_alert_o}, 32'h0);
    clear_all();
    test_we_i = 1; test_idx_i = 5'd28;
    step();
    chk("R9 force type only", err_code_o, 32'h1000_0000);
    clear_all();
    test_we_i = 1; test_idx_i = 5'd2;
    step();
    chk("R9 force source", err_code_o, 32'h0000_0004);
  endtask

  task automatic t_locked();
    clear_all();
    regs_wen_i = 0;
    test_we_i = 1; test_idx_i = 5'd20;
    step();
    chk("R10 locked code", err_code_o, 32'h0);
    chk("R10 locked alert", {31'b0, fatal_alert_o}, 32'h0);
    regs_wen_i = 1;
  endtask

  task automatic t_unused();
    clear_all();
    regs_wen_i = 1;
    test_we_i = 1; test_idx_i = 5'd5;
    step();
    chk("R11 unused idx 5", err_code_o, 32'h0);
    test_we_i = 1; test_idx_i = 5'd31;
    step();
    chk("R11 unused idx 31", err_code_o, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    regs_wen_i = 1; irq_en_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_fifo();
    t_fsm();
    t_sticky();
    t_collide();
    t_force();
    t_locked();
    t_unused();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule